// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block is a 16-bit accumulator driven by one asynchronous input pin. It has two modes. In event mode it adds one to the count for each qualifying transition of the pin. In gated mode it adds one for each divide-by-64 prescaler tick that arrives while the pin holds a chosen level. The pin passes through a synchroniser before any logic looks at it. The prescaler tick advances only while the timer-active input is high. When the timer is off, gated accumulation stops and the prescaler keeps its phase.

Software sees a count that it can preload, plus two sticky flags. The input flag marks a counted edge in event mode and the end of an active phase in gated mode. The overflow flag marks a wrap of the count. Each flag has its own interrupt enable, and the two requests are ORed onto one interrupt line. Each flag is cleared by its own write-one strobe.

Top module: `pulse_accum`

## Requirements
- R1: After reset the count is 0x0000, both flags are 0 and `irq_o` is 0.
- R2: While `en_i` is 0, pin edges and gated ticks change neither the count nor the input flag.
- R3: In event mode (`gated_mode_i`=0), `edge_sel_i`=0 counts falling pin edges and `edge_sel_i`=1 counts rising pin edges. The opposite edge does nothing, and every counted edge sets the input flag.
- R4: In gated mode with `edge_sel_i`=0, each prescaler tick seen while the synchronised pin is high adds one to the count. Ticks seen while the pin is low are ignored. The falling edge that ends the high phase sets the input flag.
- R5: In gated mode with `edge_sel_i`=1, each prescaler tick seen while the pin is low adds one to the count. The rising edge that ends the low phase sets the input flag.
- R6: The prescaler tick occurs once every 64 clock cycles during which `timer_on_i` is 1, starting from a phase of 0 at reset. While `timer_on_i` is 0 there are no ticks and the phase is held.
- R7: An increment from 0xFFFF gives 0x0000 and sets the overflow flag.
- R8: `irq_o` is 1 exactly when (input flag AND `in_irq_en_i`) OR (overflow flag AND `ovf_irq_en_i`).
- R9: A pulse on `wr_cnt_i` loads `wr_data_i` into the count on the next edge. If an increment falls in the same cycle, the write takes priority and no increment is applied.
- R10: `clr_in_flag_i` and `clr_ovf_flag_i` clear their flags. If a flag is set and cleared in the same cycle, it ends up set.
- R11: A pin change first sampled at clock edge E shows up in the count and flags at edge E+2 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous input pin |
| en_i | input | 1 | Accumulator enable |
| gated_mode_i | input | 1 | 0 selects event mode, 1 selects gated mode |
| edge_sel_i | input | 1 | Event mode: counted edge. Gated mode: active level |
| timer_on_i | input | 1 | Timer active; allows prescaler ticks |
| in_irq_en_i | input | 1 | Input-flag interrupt enable |
| ovf_irq_en_i | input | 1 | Overflow-flag interrupt enable |
| wr_cnt_i | input | 1 | Count preload strobe |
| wr_data_i | input | 16 | Preload value |
| clr_in_flag_i | input | 1 | Clear strobe for the input flag |
| clr_ovf_flag_i | input | 1 | Clear strobe for the overflow flag |
| count_o | output | 16 | Accumulated count |
| in_flag_o | output | 1 | Input flag |
| ovf_flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Some properties are checked by assertions on every cycle. The synchroniser never reports a rise and a fall together. Prescaler ticks never come back to back. The count holds while the block is disabled and moves by at most one when no write is pending. An overflow flag only rises after the count was 0xFFFF. A flag that is set in a cycle is still set in the next cycle. The interrupt line stays low when both enables are off. Other behaviour is shown only by the bench's scenarios: which edge is counted for each mode and select value, the exact number of ticks in a timer window, the stall while the timer is off, the two-edge latency, write priority and the interrupt combinations.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  typedef enum logic {
    PACC_EVENT = 1'b0,
    PACC_GATED = 1'b1
  } pacc_mode_e;
endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], async_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;

  p_edge_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_o, fall_o}));
endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
  parameter int DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
  end

  p_tick_spaced_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/pacc_flag.sv
module pacc_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;  // set beats clear
    else if (clr_i) flag_o <= 1'b0;
  end

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pacc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV         = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             en_i,
  input  logic             gated_mode_i,
  input  logic             edge_sel_i,
  input  logic             timer_on_i,
  input  logic             in_irq_en_i,
  input  logic             ovf_irq_en_i,
  input  logic             wr_cnt_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             clr_in_flag_i,
  input  logic             clr_ovf_flag_i,
  output logic [CNT_W-1:0] count_o,
  output logic             in_flag_o,
  output logic             ovf_flag_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             pin_s, pin_rise, pin_fall, tick;
  logic             inc_raw, in_set_raw, inc, in_set, ovf_set;
  logic [CNT_W-1:0] count_q;
  pacc_mode_e       mode;

  pacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .level_o (pin_s),
    .rise_o  (pin_rise),
    .fall_o  (pin_fall)
  );

  pacc_prescale #(.DIV(DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (timer_on_i),
    .tick_o (tick)
  );

  assign mode = pacc_mode_e'(gated_mode_i);

  // edge_sel: counted edge in event mode, active level in gated mode
  always_comb begin
    unique case (mode)
      PACC_EVENT: begin
        inc_raw    = edge_sel_i ? pin_rise : pin_fall;
        in_set_raw = inc_raw;
      end
      PACC_GATED: begin
        inc_raw    = tick & (edge_sel_i ? ~pin_s : pin_s);
        in_set_raw = edge_sel_i ? pin_rise : pin_fall;
      end
      default: begin
        inc_raw    = 1'b0;
        in_set_raw = 1'b0;
      end
    endcase
  end

  assign inc     = en_i & inc_raw & ~wr_cnt_i;
  assign in_set  = en_i & in_set_raw;
  assign ovf_set = inc & (count_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       count_q <= '0;
    else if (wr_cnt_i) count_q <= wr_data_i;
    else if (inc)      count_q <= count_q + 1'b1;
  end

  pacc_flag u_in_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (in_set),
    .clr_i  (clr_in_flag_i),
    .flag_o (in_flag_o)
  );

  pacc_flag u_ovf_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovf_set),
    .clr_i  (clr_ovf_flag_i),
    .flag_o (ovf_flag_o)
  );

  assign count_o = count_q;
  assign irq_o   = (in_flag_o & in_irq_en_i) | (ovf_flag_o & ovf_irq_en_i);

  p_disabled_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_cnt_i) |=> $stable(count_q));

  p_single_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cnt_i |=> (count_q == $past(count_q) ||
                   count_q == CNT_W'($past(count_q) + 1'b1)));

  p_ovf_after_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag_o) |-> ($past(count_q) == CNT_MAX));

  p_irq_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_irq_en_i && !ovf_irq_en_i) |-> !irq_o);
endmodule

// File: tb/sim_pulse_accum.sv
`timescale 1ns/1ps
module sim_pulse_accum;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pin_i = 1'b0, en_i = 1'b0, gated_mode_i = 1'b0, edge_sel_i = 1'b0;
  logic        timer_on_i = 1'b0, in_irq_en_i = 1'b0, ovf_irq_en_i = 1'b0;
  logic        wr_cnt_i = 1'b0, clr_in_flag_i = 1'b0, clr_ovf_flag_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] count_o;
  logic        in_flag_o, ovf_flag_o, irq_o;

  int errors = 0;
  int checks = 0;
  logic [15:0] exp_cnt;

  always #4 clk_i = ~clk_i;

  pulse_accum u0 (
    .clk_i, .rst_ni, .pin_i, .en_i, .gated_mode_i, .edge_sel_i, .timer_on_i,
    .in_irq_en_i, .ovf_irq_en_i, .wr_cnt_i, .wr_data_i, .clr_in_flag_i,
    .clr_ovf_flag_i, .count_o, .in_flag_o, .ovf_flag_o, .irq_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic preload(input logic [15:0] v);
    @(negedge clk_i); wr_cnt_i = 1'b1; wr_data_i = v;
    @(negedge clk_i); wr_cnt_i = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk_i); clr_in_flag_i = 1'b1; clr_ovf_flag_i = 1'b1;
    @(negedge clk_i); clr_in_flag_i = 1'b0; clr_ovf_flag_i = 1'b0;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk_i); pin_i = v;
    wait_n(4);
  endtask

  task automatic pulse();
    set_pin(~pin_i);
    set_pin(~pin_i);
  endtask

  task automatic run_timer(input int n);
    @(negedge clk_i); timer_on_i = 1'b1;
    wait_n(n);
    timer_on_i = 1'b0;
  endtask

  initial begin
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(1);
    // R1 reset state
    check("R1 count", count_o, 0);
    check("R1 in_flag", in_flag_o, 0);
    check("R1 ovf_flag", ovf_flag_o, 0);
    check("R1 irq", irq_o, 0);

    // R3 event-mode sweep over both edge selects and several pulse counts
    en_i = 1'b1;
    for (int sel = 0; sel < 2; sel++) begin
      edge_sel_i = sel[0];
      for (int n = 1; n <= 6; n++) begin
        preload(16'h0000);
        clear_flags();
        for (int p = 0; p < n; p++) pulse();
        check("R3 event count", count_o, n);
        check("R3 event flag", in_flag_o, 1);
      end
    end

    // R3 opposite edge ignored; R11 two-edge latency
    edge_sel_i = 1'b0;
    preload(16'h0010);
    clear_flags();
    set_pin(1'b1);
    check("R3 rise ignored sel0 count", count_o, 16'h0010);
    check("R3 rise ignored sel0 flag", in_flag_o, 0);
    @(negedge clk_i); pin_i = 1'b0;      // sampled at E1
    @(negedge clk_i);
    check("R11 no change after E1", count_o, 16'h0010);
    @(negedge clk_i);
    check("R11 no change after E2", count_o, 16'h0010);
    @(negedge clk_i);
    check("R11 change after E3", count_o, 16'h0011);
    check("R11 flag after E3", in_flag_o, 1);

    // R10 set and clear in the same cycle: set wins, then a lone clear clears
    @(negedge clk_i); pin_i = 1'b1;
    wait_n(4);
    clear_flags();
    @(negedge clk_i); pin_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i); clr_in_flag_i = 1'b1;
    @(negedge clk_i); clr_in_flag_i = 1'b0;
    check("R10 set wins", in_flag_o, 1);
    check("R10 set wins count", count_o, 16'h0012);
    clear_flags();
    check("R10 clear", in_flag_o, 0);

    // R9 write collides with an increment: write wins
    @(negedge clk_i); pin_i = 1'b1;
    wait_n(4);
    @(negedge clk_i); pin_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i); wr_cnt_i = 1'b1; wr_data_i = 16'h1234;
    @(negedge clk_i); wr_cnt_i = 1'b0;
    check("R9 write beats increment", count_o, 16'h1234);
    preload(16'hBEEF);
    check("R9 plain write", count_o, 16'hBEEF);

    // R2 disabled: edges ignored
    clear_flags();
    en_i = 1'b0;
    for (int p = 0; p < 5; p++) pulse();
    check("R2 count held", count_o, 16'hBEEF);
    check("R2 flag held", in_flag_o, 0);

    // R7 wrap and R8 interrupt combinations
    en_i = 1'b1;
    preload(16'hFFFE);
    clear_flags();
    pulse();
    check("R7 pre-wrap count", count_o, 16'hFFFF);
    check("R7 pre-wrap ovf", ovf_flag_o, 0);
    pulse();
    check("R7 wrap count", count_o, 16'h0000);
    check("R7 wrap ovf", ovf_flag_o, 1);
    check("R8 irq masked", irq_o, 0);
    @(negedge clk_i); ovf_irq_en_i = 1'b1; #1;
    check("R8 ovf irq", irq_o, 1);
    @(negedge clk_i); clr_ovf_flag_i = 1'b1;
    @(negedge clk_i); clr_ovf_flag_i = 1'b0; #1;
    check("R10 ovf clear", ovf_flag_o, 0);
    check("R8 irq drops", irq_o, 0);
    in_irq_en_i = 1'b1; #1;
    check("R8 in irq", irq_o, 1);
    @(negedge clk_i); clr_in_flag_i = 1'b1;
    @(negedge clk_i); clr_in_flag_i = 1'b0; #1;
    check("R8 in irq cleared", irq_o, 0);
    in_irq_en_i = 1'b0; ovf_irq_en_i = 1'b0;

    // R4/R5/R6 gated sweep; prescaler phase stays 0 (windows are multiples of 64)
    for (int sel = 0; sel < 2; sel++) begin
      en_i = 1'b0;
      gated_mode_i = 1'b1;
      edge_sel_i = sel[0];
      set_pin(sel[0] ? 1'b0 : 1'b1);     // enter active level while disabled
      preload(16'h0000);
      clear_flags();
      en_i = 1'b1;
      exp_cnt = 0;
      for (int k = 1; k <= 4; k++) begin
        run_timer(64 * k);
        exp_cnt = exp_cnt + 16'(k);
        wait_n(1);
        check(sel == 0 ? "R4 gated ticks" : "R5 gated ticks", count_o, exp_cnt);
      end
      check(sel == 0 ? "R4 no flag in phase" : "R5 no flag in phase", in_flag_o, 0);
      run_timer(63);
      wait_n(1);
      check("R6 63 cycles no tick", count_o, exp_cnt);
      run_timer(1);
      wait_n(1);
      check("R6 64th cycle ticks", count_o, exp_cnt + 16'd1);
      exp_cnt = exp_cnt + 16'd1;
      wait_n(200);
      check("R6 timer off stall", count_o, exp_cnt);
      set_pin(sel[0] ? 1'b1 : 1'b0);     // trailing edge of active phase
      check(sel == 0 ? "R4 trailing flag" : "R5 trailing flag", in_flag_o, 1);
      run_timer(128);
      wait_n(1);
      check(sel == 0 ? "R4 inactive level" : "R5 inactive level", count_o, exp_cnt);
      clear_flags();
      set_pin(sel[0] ? 1'b0 : 1'b1);
      check(sel == 0 ? "R4 leading edge no flag" : "R5 leading edge no flag", in_flag_o, 0);
      en_i = 1'b0;
      run_timer(128);
      wait_n(1);
      check("R2 gated disabled", count_o, exp_cnt);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule